// File: doc/BRIEF.md
# Concurrent Region Conflict Detector

This block watches the memory traffic of several cores. Each core splits its execution into regions. Per core, the block keeps a small table of the word addresses its current region has read and a second table of the addresses it has written. Every new data access from one core is compared with the tables of all the other cores, and with the accesses the other cores present in the same cycle. When a pair of accesses collides while the earlier region is still open, the block raises a memory-model exception. The exception holds its state until reset. It names the core whose access caused the collision and the address involved.

The block detects and reports; it restores nothing. A synchronization access is treated as a region by itself: it is never compared or recorded, and it closes the data region of its core. A region whose distinct addresses exceed a table's capacity raises a separate overflow error that also holds until reset.

Top module: `region_conflict_detector`

## Requirements
- R1: A data read from core i raises the exception when its address is in the write table of another core. Two reads of the same address never raise it.
- R2: A data write from core i raises the exception when its address is in the read table or the write table of another core.
- R3: An access with its sync bit set is never compared and never recorded. It also empties both tables of its own core, so addresses from the region before it stop causing conflicts from the next cycle on.
- R4: A region-end strobe empties both tables of its core. Stored entries still count in the strobe cycle itself, and stop counting from the next cycle. A data access presented in the same cycle as region-end is recorded as the first entry of a new open region.
- R5: A core's own accesses never conflict with each other. An address already present in a table is not inserted a second time, so repeats do not use up capacity.
- R6: Each table holds SET_DEPTH distinct addresses (default 8). A new distinct address arriving at a full table is dropped, and `overflow_err` rises one cycle later and stays high until reset.
- R7: `mm_exception` rises in the cycle after the conflicting access and stays high until reset. The first conflict loads `exc_core` and `exc_addr` with the core index and address of the access that triggered it, and later conflicts do not change them. When several cores trigger in the same cycle, the lowest core index is reported.
- R8: Data accesses to the same address from two cores in the same cycle conflict when at least one of them is a write and both cores have an open region. An open region means already open, or `region_begin` or `region_end` is asserted in that cycle.
- R9: A data access from a core with no open region is still compared with the other cores' tables, but it is not recorded.
- R10: After reset `mm_exception`, `overflow_err`, `exc_core` and `exc_addr` are all zero and every table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| region_begin | input | NUM_CORES | Per-core strobe opening a region |
| region_end | input | NUM_CORES | Per-core strobe closing the region and emptying its tables |
| acc_valid | input | NUM_CORES | Per-core access present this cycle |
| acc_addr | input | NUM_CORES*ADDR_W | Word address per core, core c at bits [c*ADDR_W +: ADDR_W] |
| acc_write | input | NUM_CORES | 1 = write, 0 = read |
| acc_sync | input | NUM_CORES | 1 = synchronization access |
| mm_exception | output | 1 | Sticky memory-model exception |
| exc_core | output | CORE_W | Index of the core whose access triggered the exception |
| exc_addr | output | ADDR_W | Address of the triggering access |
| overflow_err | output | 1 | Sticky table-capacity error |

## Verification
The hardest situation to reach is a full table meeting a new distinct address. The bench fills one core's write table with eight distinct addresses, repeating some of them on the way to confirm that repeats take no space. It then sends a ninth address. A probe read from another core proves that the ninth address was dropped while the first one is still held. Same-cycle collisions, including one where one side has no open region, are produced by driving two cores in the same step. A behavioural model built on queues predicts every output after every clock.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

  // Index of the lowest set bit, 0 when none is set.
  function automatic int lowest_set(input logic [31:0] v);
    int r;
    r = 0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) r = k;
    end
    return r;
  endfunction

  // Slot that prober core takes in the peer list of owner core.
  function automatic int peer_slot(input int owner, input int prober);
    return (prober < owner) ? prober : prober - 1;
  endfunction

  // Core held in a slot of the peer list of owner core.
  function automatic int peer_core(input int owner, input int slot);
    return (slot < owner) ? slot : slot + 1;
  endfunction

  // Two accesses to one address collide when either one writes.
  function automatic logic pair_collides(input logic same_addr, input logic wr_a,
                                         input logic wr_b);
    return same_addr & (wr_a | wr_b);
  endfunction

endpackage

// File: rtl/rcd_addr_set.sv
module rcd_addr_set #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int NPROBE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     ins_en,
  input  logic [ADDR_W-1:0]        ins_addr,
  input  logic [NPROBE*ADDR_W-1:0] probe_addr,
  output logic [NPROBE-1:0]        probe_hit,
  output logic                     ovf_evt
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [ADDR_W-1:0] entry_q [DEPTH];
  logic [CNT_W-1:0]  count_q;
  logic              self_hit;
  logic              full;

  assign full = (count_q == CNT_W'(DEPTH));

  always_comb begin
    self_hit = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((CNT_W'(k) < count_q) && (entry_q[k] == ins_addr)) self_hit = 1'b1;
    end
  end

  for (genvar p = 0; p < NPROBE; p++) begin : g_probe
    always_comb begin
      probe_hit[p] = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
        if ((CNT_W'(k) < count_q) && (entry_q[k] == probe_addr[p*ADDR_W +: ADDR_W]))
          probe_hit[p] = 1'b1;
      end
    end
  end

  assign ovf_evt = ins_en & ~clear & ~self_hit & full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear) begin
      count_q <= ins_en ? CNT_W'(1) : '0;
      if (ins_en) entry_q[0] <= ins_addr;
    end else if (ins_en && !self_hit && !full) begin
      entry_q[count_q[IDX_W-1:0]] <= ins_addr;
      count_q <= count_q + CNT_W'(1);
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
  assert_ovf_keeps_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> count_q == CNT_W'(DEPTH));
  assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !ins_en) |=> count_q == '0);

endmodule

// File: rtl/rcd_core_track.sv
module rcd_core_track #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int NPROBE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_begin,
  input  logic                     reg_end,
  input  logic                     acc_valid,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic                     acc_write,
  input  logic                     acc_sync,
  input  logic [NPROBE*ADDR_W-1:0] probe_addr,
  output logic [NPROBE-1:0]        rd_probe_hit,
  output logic [NPROBE-1:0]        wr_probe_hit,
  output logic                     data_acc,
  output logic                     rec_acc,
  output logic                     ovf_evt
);
  logic open_q;
  logic clear_sets;
  logic rd_ovf, wr_ovf;

  assign data_acc   = acc_valid & ~acc_sync;
  assign rec_acc    = data_acc & (open_q | reg_begin | reg_end);
  assign clear_sets = reg_end | (acc_valid & acc_sync);
  assign ovf_evt    = rd_ovf | wr_ovf;

  always_ff @(posedge clk) begin
    if (!rst_n)       open_q <= 1'b0;
    else if (reg_end) open_q <= data_acc;
    else              open_q <= open_q | reg_begin;
  end

  rcd_addr_set #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .NPROBE(NPROBE)) u_rd_set (
    .clk(clk), .rst_n(rst_n), .clear(clear_sets),
    .ins_en(rec_acc & ~acc_write), .ins_addr(acc_addr),
    .probe_addr(probe_addr), .probe_hit(rd_probe_hit), .ovf_evt(rd_ovf));

  rcd_addr_set #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .NPROBE(NPROBE)) u_wr_set (
    .clk(clk), .rst_n(rst_n), .clear(clear_sets),
    .ins_en(rec_acc & acc_write), .ins_addr(acc_addr),
    .probe_addr(probe_addr), .probe_hit(wr_probe_hit), .ovf_evt(wr_ovf));

  assert_end_with_access_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_end && data_acc) |=> open_q);

endmodule

// File: rtl/region_conflict_detector.sv
module region_conflict_detector #(
  parameter int NUM_CORES = 3,
  parameter int ADDR_W    = 16,
  parameter int SET_DEPTH = 8,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES-1:0]        region_begin,
  input  logic [NUM_CORES-1:0]        region_end,
  input  logic [NUM_CORES-1:0]        acc_valid,
  input  logic [NUM_CORES*ADDR_W-1:0] acc_addr,
  input  logic [NUM_CORES-1:0]        acc_write,
  input  logic [NUM_CORES-1:0]        acc_sync,
  output logic                        mm_exception,
  output logic [CORE_W-1:0]           exc_core,
  output logic [ADDR_W-1:0]           exc_addr,
  output logic                        overflow_err
);
  import rcd_pkg::*;

  localparam int NPEER = NUM_CORES - 1;

  logic [ADDR_W-1:0]  addr_arr [NUM_CORES];
  logic [NPEER-1:0]   rd_hit   [NUM_CORES];
  logic [NPEER-1:0]   wr_hit   [NUM_CORES];
  logic [NUM_CORES-1:0] data_acc, rec_acc, ovf_evt, conflict_vec;
  logic               exc_q, ovf_q;
  logic [CORE_W-1:0]  core_q;
  logic [ADDR_W-1:0]  addr_q;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NPEER*ADDR_W-1:0] peer_addr;
    assign addr_arr[c] = acc_addr[c*ADDR_W +: ADDR_W];
    for (genvar s = 0; s < NPEER; s++) begin : g_peer
      localparam int PC = peer_core(c, s);
      assign peer_addr[s*ADDR_W +: ADDR_W] = acc_addr[PC*ADDR_W +: ADDR_W];
    end
    rcd_core_track #(.DEPTH(SET_DEPTH), .ADDR_W(ADDR_W), .NPROBE(NPEER)) u_track (
      .clk(clk), .rst_n(rst_n), .reg_begin(region_begin[c]), .reg_end(region_end[c]),
      .acc_valid(acc_valid[c]), .acc_addr(addr_arr[c]), .acc_write(acc_write[c]),
      .acc_sync(acc_sync[c]), .probe_addr(peer_addr),
      .rd_probe_hit(rd_hit[c]), .wr_probe_hit(wr_hit[c]),
      .data_acc(data_acc[c]), .rec_acc(rec_acc[c]), .ovf_evt(ovf_evt[c]));
  end

  // Cross check: prober i against every peer j's tables and same-cycle access.
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_check
    always_comb begin
      conflict_vec[i] = 1'b0;
      for (int j = 0; j < NUM_CORES; j++) begin
        if (j != i) begin
          if (data_acc[i] && (wr_hit[j][peer_slot(j, i)] ||
                              (acc_write[i] && rd_hit[j][peer_slot(j, i)])))
            conflict_vec[i] = 1'b1;
          if (rec_acc[i] && rec_acc[j] &&
              pair_collides(addr_arr[i] == addr_arr[j], acc_write[i], acc_write[j]))
            conflict_vec[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_q  <= 1'b0;
      ovf_q  <= 1'b0;
      core_q <= '0;
      addr_q <= '0;
    end else begin
      ovf_q <= ovf_q | (|ovf_evt);
      if (!exc_q && (|conflict_vec)) begin
        exc_q  <= 1'b1;
        core_q <= CORE_W'(lowest_set(32'(conflict_vec)));
        addr_q <= addr_arr[lowest_set(32'(conflict_vec))];
      end
    end
  end

  assign mm_exception = exc_q;
  assign exc_core     = core_q;
  assign exc_addr     = addr_q;
  assign overflow_err = ovf_q;

  assert_exc_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_q |=> exc_q && $stable(core_q) && $stable(addr_q));
  assert_conflict_raises_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|conflict_vec) |=> exc_q);
  assert_sync_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_q && !(|data_acc)) |=> !exc_q);
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  assert_ovf_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_q && !(|ovf_evt)) |=> !ovf_q);

endmodule

// File: tb/region_conflict_detector_bench.sv
module region_conflict_detector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 3;
  localparam int AW = 16;
  localparam int DEPTH = 8;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] beg_v = '0, end_v = '0, val_v = '0, wr_v = '0, sy_v = '0;
  logic [AW-1:0] ad_v [NC];
  logic [NC*AW-1:0] addr_flat;
  logic mm_exception, overflow_err;
  logic [CW-1:0] exc_core;
  logic [AW-1:0] exc_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  int  rset [NC][$];
  int  wset [NC][$];
  bit  open_m [NC];
  bit  exc_m, ovf_m;
  int  core_m, addr_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < NC; c++) addr_flat[c*AW +: AW] = ad_v[c];
  end

  region_conflict_detector #(.NUM_CORES(NC), .ADDR_W(AW), .SET_DEPTH(DEPTH)) u_region_conflict_detector (
    .clk(clk), .rst_n(rst_n), .region_begin(beg_v), .region_end(end_v),
    .acc_valid(val_v), .acc_addr(addr_flat), .acc_write(wr_v), .acc_sync(sy_v),
    .mm_exception(mm_exception), .exc_core(exc_core), .exc_addr(exc_addr),
    .overflow_err(overflow_err));

  function automatic bit in_q(int q[$], int x);
    foreach (q[k]) if (q[k] == x) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    beg_v = '0; end_v = '0; val_v = '0; wr_v = '0; sy_v = '0;
    for (int c = 0; c < NC; c++) ad_v[c] = '0;
  endtask

  task automatic acc(input int c, input int a, input bit w, input bit s);
    val_v[c] = 1'b1; ad_v[c] = AW'(a); wr_v[c] = w; sy_v[c] = s;
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      rset[c].delete(); wset[c].delete(); open_m[c] = 0;
    end
    exc_m = 0; ovf_m = 0; core_m = 0; addr_m = 0;
  endtask

  // One clock: model predicts from the applied inputs, outputs compared after the edge.
  task automatic step(input string tag);
    bit dat [NC];
    bit rec [NC];
    int first;
    @(negedge clk);
    first = -1;
    for (int c = 0; c < NC; c++) begin
      dat[c] = val_v[c] && !sy_v[c];
      rec[c] = dat[c] && (open_m[c] || beg_v[c] || end_v[c]);
    end
    for (int i = 0; i < NC; i++) begin
      bit hit = 0;
      for (int j = 0; j < NC; j++) begin
        if (j == i) continue;
        if (dat[i] && in_q(wset[j], int'(ad_v[i]))) hit = 1;
        if (dat[i] && wr_v[i] && in_q(rset[j], int'(ad_v[i]))) hit = 1;
        if (rec[i] && rec[j] && ad_v[i] == ad_v[j] && (wr_v[i] || wr_v[j])) hit = 1;
      end
      if (hit && first < 0) first = i;
    end
    if (!exc_m && first >= 0) begin
      exc_m = 1; core_m = first; addr_m = int'(ad_v[first]);
    end
    for (int c = 0; c < NC; c++) begin
      if (end_v[c] || (val_v[c] && sy_v[c])) begin
        rset[c].delete(); wset[c].delete();
      end
      if (rec[c]) begin
        if (wr_v[c]) begin
          if (!in_q(wset[c], int'(ad_v[c]))) begin
            if (wset[c].size() < DEPTH) wset[c].push_back(int'(ad_v[c])); else ovf_m = 1;
          end
        end else begin
          if (!in_q(rset[c], int'(ad_v[c]))) begin
            if (rset[c].size() < DEPTH) rset[c].push_back(int'(ad_v[c])); else ovf_m = 1;
          end
        end
      end
      open_m[c] = end_v[c] ? dat[c] : (open_m[c] || beg_v[c]);
    end
    @(posedge clk);
    #1;
    check(tag, "mm_exception", int'(mm_exception), int'(exc_m));
    check(tag, "exc_core", int'(exc_core), core_m);
    check(tag, "exc_addr", int'(exc_addr), addr_m);
    check(tag, "overflow_err", int'(overflow_err), int'(ovf_m));
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    step("R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    do_reset();                                       // R10 reset state

    // R1: read hits another core's write table; read/read is quiet
    beg_v[0] = 1; beg_v[1] = 1; step("R1");
    acc(0, 'h20, 0, 0); step("R1");
    acc(1, 'h20, 0, 0); step("R1");
    acc(0, 'h10, 1, 0); step("R1");
    acc(1, 'h10, 0, 0); step("R1");
    step("R1");

    // R2: write against read table, then write against write table
    do_reset();
    beg_v = '1; step("R2");
    acc(0, 'h30, 0, 0); step("R2");
    acc(2, 'h30, 1, 0); step("R2");
    do_reset();
    beg_v = '1; step("R2");
    acc(0, 'h31, 1, 0); step("R2");
    acc(2, 'h31, 1, 0); step("R2");

    // R3: sync accesses neither conflict nor record, and clear own tables
    do_reset();
    beg_v = '1; step("R3");
    acc(0, 'h40, 1, 1); step("R3");
    acc(1, 'h40, 1, 1); step("R3");
    acc(1, 'h40, 0, 0); step("R3");
    acc(0, 'h41, 1, 0); step("R3");
    acc(0, 'h99, 0, 1); step("R3");
    acc(1, 'h41, 1, 0); step("R3");

    // R4: end-cycle entries still count; afterwards gone; access with end opens next region
    do_reset();
    beg_v = '1; step("R4");
    acc(0, 'h50, 1, 0); step("R4");
    end_v[0] = 1; acc(1, 'h52, 0, 0); step("R4");
    acc(1, 'h50, 0, 0); step("R4");
    end_v[0] = 1; acc(0, 'h51, 1, 0); step("R4");
    acc(1, 'h51, 0, 0); step("R4");
    do_reset();
    beg_v = '1; step("R4");
    acc(0, 'h53, 1, 0); step("R4");
    end_v[0] = 1; acc(1, 'h53, 0, 0); step("R4");

    // R5: own accesses never collide; repeats take no space
    do_reset();
    beg_v = '1; step("R5");
    acc(0, 'h60, 1, 0); step("R5");
    acc(0, 'h60, 0, 0); step("R5");
    acc(0, 'h60, 1, 0); step("R5");
    for (int k = 0; k < 7; k++) begin
      acc(0, 'h61 + k, 1, 0); step("R5");
      acc(0, 'h60, 1, 0); step("R5");
    end

    // R6: ninth distinct address overflows and is dropped
    do_reset();
    beg_v = '1; step("R6");
    for (int k = 0; k < 9; k++) begin
      acc(0, 'hA0 + k, 1, 0); step("R6");
    end
    step("R6");
    acc(1, 'hA8, 0, 0); step("R6");
    acc(1, 'hA0, 0, 0); step("R6");
    acc(1, 'hA1, 0, 0); step("R6");

    // R7: tie goes to lowest index; later conflicts leave the record alone
    do_reset();
    beg_v = '1; step("R7");
    acc(0, 'h70, 1, 0); step("R7");
    acc(1, 'h70, 0, 0); acc(2, 'h70, 0, 0); step("R7");
    acc(2, 'h70, 1, 0); step("R7");
    step("R7");

    // R8: same-cycle collision between open regions
    do_reset();
    beg_v[0] = 1; beg_v[1] = 1; step("R8");
    acc(1, 'h80, 0, 0); acc(0, 'h80, 1, 0); step("R8");
    do_reset();
    beg_v[0] = 1; step("R8");
    acc(0, 'h81, 0, 0); acc(2, 'h81, 1, 0); step("R8");
    acc(1, 'h82, 0, 0); acc(2, 'h82, 0, 0); beg_v[1] = 1; beg_v[2] = 1; step("R8");

    // R9: no open region: not recorded, yet still checked
    do_reset();
    acc(2, 'h90, 1, 0); step("R9");
    acc(1, 'h90, 0, 0); step("R9");
    beg_v[0] = 1; step("R9");
    acc(0, 'h91, 0, 0); step("R9");
    acc(2, 'h91, 1, 0); step("R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule